// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory. A requester presents an address together with the access kind (read or write) and the privilege (user or supervisor). The walker then fetches a directory entry and, for a normal 4 KB page, a table entry. It checks present and permission bits. On success it writes back the accessed and dirty status bits that need setting. It then returns either the physical address with its attributes or a fault with a three-bit error code. Only one translation is in flight at a time.

Memory is reached through a single request/response port. A request is a one-cycle pulse carrying an address, a write flag and write data. The reply is a one-cycle `mem_resp_valid` pulse, which carries read data for reads and is a plain acknowledge for writes. When the large-page enable is high, a directory entry with its page-size bit set ends the walk at the first level and maps a 4 MB page.

The sequencer has eleven states:
- `S_IDLE` goes to `S_DIR_RD` on an accepted request.
- `S_DIR_RD` issues the directory read and goes to `S_DIR_WAIT`.
- `S_DIR_WAIT` goes to `S_DONE` if the entry is not present, to `S_CHECK` if it maps a large page, and otherwise to `S_TBL_RD`.
- `S_TBL_RD` goes to `S_TBL_WAIT`.
- `S_TBL_WAIT` goes to `S_DONE` if the entry is not present, and otherwise to `S_CHECK`.
- `S_CHECK` goes to `S_DONE` on a protection fault, to `S_DIR_WB` if the directory entry needs an update, to `S_TBL_WB` if only the table entry does, and otherwise to `S_DONE`.
- `S_DIR_WB` goes to `S_DIR_WB_WAIT`, which then goes to `S_TBL_WB` or `S_DONE`.
- `S_TBL_WB` goes to `S_TBL_WB_WAIT`, which then goes to `S_DONE`.
- `S_DONE` goes back to `S_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: The first memory request of a walk is a read at address `{dir_base, va[31:22], 2'b00}`. `dir_base` is the 20-bit frame number of the directory.
- R2: For a 4 KB walk, the second read is at `{pde[31:12], va[21:12], 2'b00}`. On success `res_pa = {pte[31:12], va[11:0]}`.
- R3: When `large_en` is high and directory entry bit 7 is 1, the walk performs exactly one read and gives `res_pa = {pde[31:22], va[21:0]}` with `res_large` = 1. When `large_en` is low, bit 7 is ignored and two reads are made.
- R4: Entry bit 0 is present, bit 1 is writable (0 = read-only), bit 2 is user-accessible (0 = supervisor only), bit 5 is accessed and bit 6 is dirty. Bits 11:9 have no effect on the result and are preserved by write-back.
- R5: A clear present bit in either entry ends the walk with `fault` = 1 and `fault_code[0]` = 0. No write is issued.
- R6: The effective writable and user bits are the AND of both levels (only the directory level for a large page). A user access without user permission, or a write without write permission, gives `fault` = 1 and `fault_code[0]` = 1, and no write is issued.
- R7: On any fault, `fault_code[1]` equals the request's write flag and `fault_code[2]` equals its user flag.
- R8: On success, each entry used whose accessed bit is 0 is rewritten as its read value with bit 5 set. The leaf entry of a write also gets bit 6 set. An entry that needs no change is not written.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. Request inputs are ignored while busy. `done` is a one-cycle pulse. Each memory request is a one-cycle pulse with at most one outstanding.
- R10: After reset, `busy`, `done` and `mem_req_valid` are 0.
- R11: On success, `res_rw` and `res_us` give the effective permissions, `res_cattr` gives leaf bits 4:3 and `res_global` gives leaf bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 20 | Frame number of the page directory |
| large_en | input | 1 | Honour the page-size bit in directory entries |
| req_valid | input | 1 | Translation request, accepted when idle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle memory request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_resp_valid | input | 1 | Memory reply (read data or write acknowledge) |
| mem_resp_rdata | input | 32 | Read data |
| done | output | 1 | Result valid for one cycle |
| fault | output | 1 | Translation failed |
| fault_code | output | 3 | {user, write, protection} |
| res_pa | output | 32 | Physical address |
| res_rw | output | 1 | Effective writable |
| res_us | output | 1 | Effective user-accessible |
| res_large | output | 1 | Mapping is a 4 MB page |
| res_cattr | output | 2 | Leaf cache attribute bits, passed through |
| res_global | output | 1 | Leaf global bit, passed through |

## Verification
The bench sweeps every combination of present, writable and user bits at both levels, together with the directory page-size bit, the large-page enable, access kind, privilege and the leaf's accessed and dirty bits. That is 4096 walks with memory latency varied from one to three cycles. Entry addresses and read counts show which level ended the walk and whether the page-size bit was gated. The fault code and the memory contents after the walk separate not-present from protection faults and confirm that only the needed status bits were set. Scrambled request inputs held during every walk, plus random filler in the ignored and pass-through bits, show that neither reaches the result except through the attribute outputs.

// File: rtl/walker_pkg.sv
package walker_pkg;
    localparam int WORD_W  = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int FRAME_W = WORD_W - OFF_W;
    localparam int BIG_W   = WORD_W - OFF_W - IDX_W;
    localparam int ENT_SH  = WORD_W - FRAME_W - IDX_W;
    localparam int CODE_W  = 3;
    localparam int CATTR_W = 2;

    // entry bit positions (the walker decodes these)
    localparam int B_PRES  = 0;
    localparam int B_WRITE = 1;
    localparam int B_USER  = 2;
    localparam int B_CA_LO = 3;
    localparam int B_ACC   = 5;
    localparam int B_DIRTY = 6;
    localparam int B_SIZE  = 7;
    localparam int B_GLOB  = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DIR_RD,
        S_DIR_WAIT,
        S_TBL_RD,
        S_TBL_WAIT,
        S_CHECK,
        S_DIR_WB,
        S_DIR_WB_WAIT,
        S_TBL_WB,
        S_TBL_WB_WAIT,
        S_DONE
    } walk_state_t;
endpackage

// File: rtl/walk_addr.sv
module walk_addr
    import walker_pkg::*;
(
    input  logic [FRAME_W-1:0] base_frame,
    input  logic [WORD_W-1:0]  va,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [FRAME_W-1:0] leaf_frame,
    input  logic               big,
    output logic [WORD_W-1:0]  dir_addr,
    output logic [WORD_W-1:0]  tbl_addr,
    output logic [WORD_W-1:0]  phys
);
    localparam int DIR_LO = OFF_W + IDX_W;

    assign dir_addr = {base_frame, va[WORD_W-1:DIR_LO], {ENT_SH{1'b0}}};
    assign tbl_addr = {dir_frame, va[DIR_LO-1:OFF_W], {ENT_SH{1'b0}}};

    always_comb begin
        if (big) begin
            phys = {dir_frame[FRAME_W-1 -: BIG_W], va[DIR_LO-1:0]};
        end else begin
            phys = {leaf_frame, va[OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/walk_perm.sv
module walk_perm
    import walker_pkg::*;
(
    input  logic [WORD_W-1:0]  dir_ent,
    input  logic [WORD_W-1:0]  tbl_ent,
    input  logic               big,
    input  logic               wr,
    input  logic               user,
    output logic               prot_fault,
    output logic               eff_rw,
    output logic               eff_us,
    output logic [WORD_W-1:0]  dir_new,
    output logic [WORD_W-1:0]  tbl_new,
    output logic               dir_upd,
    output logic               tbl_upd,
    output logic [CATTR_W-1:0] leaf_cattr,
    output logic               leaf_glob
);
    logic [WORD_W-1:0] leaf;
    logic [WORD_W-1:0] dir_set;
    logic [WORD_W-1:0] tbl_set;

    always_comb begin
        leaf       = big ? dir_ent : tbl_ent;
        eff_rw     = dir_ent[B_WRITE] & (big | tbl_ent[B_WRITE]);
        eff_us     = dir_ent[B_USER]  & (big | tbl_ent[B_USER]);
        prot_fault = (user & ~eff_us) | (wr & ~eff_rw);

        dir_set          = '0;
        dir_set[B_ACC]   = 1'b1;
        dir_set[B_DIRTY] = big & wr;
        tbl_set          = '0;
        tbl_set[B_ACC]   = 1'b1;
        tbl_set[B_DIRTY] = wr;

        dir_new = dir_ent | dir_set;
        tbl_new = tbl_ent | tbl_set;
        dir_upd = (dir_new != dir_ent);
        tbl_upd = ~big & (tbl_new != tbl_ent);

        leaf_cattr = leaf[B_CA_LO +: CATTR_W];
        leaf_glob  = leaf[B_GLOB];
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import walker_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FRAME_W-1:0]   dir_base,
    input  logic                 large_en,
    input  logic                 req_valid,
    input  logic [WORD_W-1:0]    req_va,
    input  logic                 req_write,
    input  logic                 req_user,
    output logic                 busy,
    output logic                 mem_req_valid,
    output logic                 mem_req_we,
    output logic [WORD_W-1:0]    mem_req_addr,
    output logic [WORD_W-1:0]    mem_req_wdata,
    input  logic                 mem_resp_valid,
    input  logic [WORD_W-1:0]    mem_resp_rdata,
    output logic                 done,
    output logic                 fault,
    output logic [CODE_W-1:0]    fault_code,
    output logic [WORD_W-1:0]    res_pa,
    output logic                 res_rw,
    output logic                 res_us,
    output logic                 res_large,
    output logic [CATTR_W-1:0]   res_cattr,
    output logic                 res_global
);
    walk_state_t state_q, state_d;

    logic [FRAME_W-1:0] base_q;
    logic [WORD_W-1:0]  va_q, pde_q, pte_q;
    logic               wr_q, user_q, big_en_q, big_q, wrote_q;
    logic [1:0]         rd_cnt_q;

    logic [WORD_W-1:0]  dir_addr, tbl_addr, phys;
    logic [WORD_W-1:0]  dir_new, tbl_new;
    logic               prot_fault, eff_rw, eff_us, dir_upd, tbl_upd, leaf_glob;
    logic [CATTR_W-1:0] leaf_cattr;

    logic               accept, dir_miss, tbl_miss, go_big;

    walk_addr u_addr (
        .base_frame (base_q),
        .va         (va_q),
        .dir_frame  (pde_q[WORD_W-1:OFF_W]),
        .leaf_frame (pte_q[WORD_W-1:OFF_W]),
        .big        (big_q),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr),
        .phys       (phys)
    );

    walk_perm u_perm (
        .dir_ent    (pde_q),
        .tbl_ent    (pte_q),
        .big        (big_q),
        .wr         (wr_q),
        .user       (user_q),
        .prot_fault (prot_fault),
        .eff_rw     (eff_rw),
        .eff_us     (eff_us),
        .dir_new    (dir_new),
        .tbl_new    (tbl_new),
        .dir_upd    (dir_upd),
        .tbl_upd    (tbl_upd),
        .leaf_cattr (leaf_cattr),
        .leaf_glob  (leaf_glob)
    );

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign dir_miss = (state_q == S_DIR_WAIT) && mem_resp_valid && !mem_resp_rdata[B_PRES];
    assign tbl_miss = (state_q == S_TBL_WAIT) && mem_resp_valid && !mem_resp_rdata[B_PRES];
    assign go_big   = big_en_q && mem_resp_rdata[B_SIZE];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:        if (req_valid) state_d = S_DIR_RD;
            S_DIR_RD:      state_d = S_DIR_WAIT;
            S_DIR_WAIT: begin
                if (mem_resp_valid) begin
                    if (!mem_resp_rdata[B_PRES]) state_d = S_DONE;
                    else if (go_big)             state_d = S_CHECK;
                    else                         state_d = S_TBL_RD;
                end
            end
            S_TBL_RD:      state_d = S_TBL_WAIT;
            S_TBL_WAIT: begin
                if (mem_resp_valid) begin
                    state_d = mem_resp_rdata[B_PRES] ? S_CHECK : S_DONE;
                end
            end
            S_CHECK: begin
                if (prot_fault)   state_d = S_DONE;
                else if (dir_upd) state_d = S_DIR_WB;
                else if (tbl_upd) state_d = S_TBL_WB;
                else              state_d = S_DONE;
            end
            S_DIR_WB:      state_d = S_DIR_WB_WAIT;
            S_DIR_WB_WAIT: begin
                if (mem_resp_valid) state_d = tbl_upd ? S_TBL_WB : S_DONE;
            end
            S_TBL_WB:      state_d = S_TBL_WB_WAIT;
            S_TBL_WB_WAIT: if (mem_resp_valid) state_d = S_DONE;
            S_DONE:        state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    // walk context and captured entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            va_q     <= '0;
            wr_q     <= 1'b0;
            user_q   <= 1'b0;
            big_en_q <= 1'b0;
            big_q    <= 1'b0;
            pde_q    <= '0;
            pte_q    <= '0;
            rd_cnt_q <= '0;
            wrote_q  <= 1'b0;
        end else begin
            if (accept) begin
                base_q   <= dir_base;
                va_q     <= req_va;
                wr_q     <= req_write;
                user_q   <= req_user;
                big_en_q <= large_en;
                big_q    <= 1'b0;
                rd_cnt_q <= '0;
                wrote_q  <= 1'b0;
            end
            if (state_q == S_DIR_WAIT && mem_resp_valid) begin
                pde_q <= mem_resp_rdata;
                big_q <= mem_resp_rdata[B_PRES] && go_big;
            end
            if (state_q == S_TBL_WAIT && mem_resp_valid) begin
                pte_q <= mem_resp_rdata;
            end
            if (mem_req_valid && !mem_req_we && rd_cnt_q != 2'd3) begin
                rd_cnt_q <= rd_cnt_q + 2'd1;
            end
            if (mem_req_valid && mem_req_we) begin
                wrote_q <= 1'b1;
            end
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault      <= 1'b0;
            fault_code <= '0;
            res_pa     <= '0;
            res_rw     <= 1'b0;
            res_us     <= 1'b0;
            res_large  <= 1'b0;
            res_cattr  <= '0;
            res_global <= 1'b0;
        end else if (dir_miss || tbl_miss) begin
            fault      <= 1'b1;
            fault_code <= {user_q, wr_q, 1'b0};
            res_pa     <= '0;
            res_rw     <= 1'b0;
            res_us     <= 1'b0;
            res_large  <= 1'b0;
            res_cattr  <= '0;
            res_global <= 1'b0;
        end else if (state_q == S_CHECK) begin
            fault      <= prot_fault;
            fault_code <= prot_fault ? {user_q, wr_q, 1'b1} : '0;
            res_pa     <= prot_fault ? '0 : phys;
            res_rw     <= ~prot_fault & eff_rw;
            res_us     <= ~prot_fault & eff_us;
            res_large  <= ~prot_fault & big_q;
            res_cattr  <= prot_fault ? '0 : leaf_cattr;
            res_global <= ~prot_fault & leaf_glob;
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != S_IDLE);
        done          = (state_q == S_DONE);
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        unique case (state_q)
            S_DIR_RD: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dir_addr;
            end
            S_TBL_RD: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tbl_addr;
            end
            S_DIR_WB: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = dir_addr;
                mem_req_wdata = dir_new;
            end
            S_TBL_WB: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = tbl_addr;
                mem_req_wdata = tbl_new;
            end
            default: ;
        endcase
    end

    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && !fault_code[0]) |-> !wrote_q);

    // R6
    prot_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && fault_code[0]) |-> !wrote_q);

    // R7
    code_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code[1] == wr_q && fault_code[2] == user_q));

    // R3
    big_one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && res_large) |-> (rd_cnt_q == 2'd1));

    // R2
    small_two_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && !res_large) |-> (rd_cnt_q == 2'd2));

    // R8
    wb_marks_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_wdata[B_ACC] && mem_req_wdata[B_PRES]));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    import walker_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] dir_base = '0;
    logic        large_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        busy;
    logic        mem_req_valid, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_rdata = '0;
    logic        done, fault;
    logic [2:0]  fault_code;
    logic [31:0] res_pa;
    logic        res_rw, res_us, res_large, res_global;
    logic [1:0]  res_cattr;

    always #4 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .dir_base(dir_base), .large_en(large_en),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata),
        .done(done), .fault(fault), .fault_code(fault_code), .res_pa(res_pa),
        .res_rw(res_rw), .res_us(res_us), .res_large(res_large),
        .res_cattr(res_cattr), .res_global(res_global)
    );

    logic [31:0] mem [bit [29:0]];
    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [31:0] rdm(input logic [31:0] a);
        if (mem.exists(a[31:2])) return mem[a[31:2]];
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model and result monitor
    logic        pend = 1'b0;
    int          lat = 0;
    int          lat_sel = 0;
    logic [31:0] pend_data = '0;
    int          rd_n = 0, wr_n = 0, done_n = 0;
    logic [31:0] rd_a0 = '0, rd_a1 = '0;
    logic        c_fault, c_rw, c_us, c_large, c_glob;
    logic [2:0]  c_code;
    logic [31:0] c_pa;
    logic [1:0]  c_cattr;

    always @(negedge clk) begin
        mem_resp_valid = 1'b0;
        if (pend) begin
            if (lat == 0) begin
                mem_resp_valid = 1'b1;
                mem_resp_rdata = pend_data;
                pend = 1'b0;
            end else begin
                lat--;
            end
        end
        if (mem_req_valid) begin
            if (mem_req_we) begin
                mem[mem_req_addr[31:2]] = mem_req_wdata;
                wr_n++;
                pend_data = 32'h0;
            end else begin
                if (rd_n == 0) rd_a0 = mem_req_addr;
                else if (rd_n == 1) rd_a1 = mem_req_addr;
                rd_n++;
                pend_data = rdm(mem_req_addr);
            end
            pend = 1'b1;
            lat = lat_sel;
        end
        if (done) begin
            done_n++;
            c_fault = fault; c_code = fault_code; c_pa = res_pa;
            c_rw = res_rw; c_us = res_us; c_large = res_large;
            c_cattr = res_cattr; c_glob = res_global;
        end
    end

    initial begin
        logic hung;
        hung = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10 reset state
        chk("R10 busy after reset", {31'b0, busy}, 32'h0);
        chk("R10 done after reset", {31'b0, done}, 32'h0);
        chk("R10 mem_req_valid after reset", {31'b0, mem_req_valid}, 32'h0);

        for (int v = 0; v < 4096 && !hung; v++) begin
            logic [11:0] b;
            logic [31:0] h, h2, pde, pte, va, pde_addr, pte_addr, pde_exp, pte_exp, pa_exp, leaf;
            logic [19:0] base;
            logic [9:0]  di, ti;
            logic [11:0] off;
            logic        pa_p, pa_rw, pa_us, pa_ps, pt_p, pt_rw, pt_us, wr, usr, len, pt_a, pt_d;
            logic        big, present, prot, fl, rw_e, us_e;
            int          reads_e, writes_e, d0, waits;
            logic        busy_ok;

            b = 12'(v);
            {pt_d, pt_a, len, usr, wr, pt_us, pt_rw, pt_p, pa_ps, pa_us, pa_rw, pa_p} = b;
            h  = 32'(v) * 32'd40503;
            h2 = 32'(v) * 32'h9E3779B1;
            base = 20'h00100 + 20'(v % 5);
            di  = 10'((v * 37) % 1024);
            ti  = 10'((v * 91 + 5) % 1024);
            off = 12'((v * 13) % 4096);
            va  = {di, ti, off};
            pde = {20'h00200 + 20'(v), h[3:0], pa_ps, b[2] ^ b[11], b[1] ^ b[4] ^ b[10],
                   h[5:4], pa_us, pa_rw, pa_p};
            pte = {h2[31:12], h2[7:4], h2[8], pt_d, pt_a, h2[10:9], pt_us, pt_rw, pt_p};
            pde_addr = {base, di, 2'b00};
            pte_addr = {pde[31:12], ti, 2'b00};
            mem[pde_addr[31:2]] = pde;
            mem[pte_addr[31:2]] = pte;

            // expected outcome
            big     = len & pa_ps;
            present = pa_p & (big | pt_p);
            reads_e = (!pa_p || big) ? 1 : 2;
            rw_e    = pa_rw & (big | pt_rw);
            us_e    = pa_us & (big | pt_us);
            prot    = present & ((usr & ~us_e) | (wr & ~rw_e));
            fl      = ~present | prot;
            pde_exp = pde;
            pte_exp = pte;
            if (!fl) begin
                pde_exp = pde | 32'h20 | ((big & wr) ? 32'h40 : 32'h0);
                if (!big) pte_exp = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
            end
            writes_e = int'(pde_exp != pde) + int'(pte_exp != pte);
            leaf   = big ? pde : pte;
            pa_exp = big ? {pde[31:22], va[21:0]} : {pte[31:12], va[11:0]};

            // launch
            lat_sel = v % 3;
            rd_n = 0; wr_n = 0;
            d0 = done_n;
            dir_base = base; large_en = len; req_va = va;
            req_write = wr; req_user = usr; req_valid = 1'b1;
            @(negedge clk); #1;
            // scrambled inputs while busy (R9: ignored)
            dir_base = ~base; large_en = ~len; req_va = ~va;
            req_write = ~wr; req_user = ~usr;
            busy_ok = 1'b1;
            waits = 0;
            while (done_n == d0 && waits < 60) begin
                if (!busy) busy_ok = 1'b0;
                @(negedge clk); #1;
                waits++;
            end
            req_valid = 1'b0;
            if (done_n == d0) begin
                n_chk++; n_bad++;
                $display("FAIL R9 watchdog: walk %0d actual=no done expected=done", v);
                hung = 1'b1;
            end else begin
                chk("R9 busy through walk", {31'b0, busy_ok}, 32'h1);
                chk("R1 directory entry address", rd_a0, pde_addr);
                chk("R3 read count", 32'(rd_n), 32'(reads_e));
                if (reads_e == 2) chk("R2 table entry address", rd_a1, pte_addr);
                chk(!present ? "R5 fault flag" : "R6 fault flag", {31'b0, c_fault}, {31'b0, fl});
                if (fl) begin
                    chk("R7 fault code", {29'b0, c_code}, {29'b0, usr, wr, prot});
                end else begin
                    chk(big ? "R3 large physical address" : "R2 physical address", c_pa, pa_exp);
                    chk("R11 attributes", {26'b0, c_rw, c_us, c_large, c_cattr, c_glob},
                        {26'b0, rw_e, us_e, big, leaf[4:3], leaf[8]});
                end
                chk("R8 write count", 32'(wr_n), 32'(writes_e));
                chk("R8 directory entry after walk", rdm(pde_addr), pde_exp);
                chk("R4 table entry after walk", rdm(pte_addr), pte_exp);
                @(negedge clk); #1;
                chk("R9 single done pulse", {30'b0, busy, done}, 32'h0);
                chk("R9 one done per walk", 32'(done_n - d0), 32'h1);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule